// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Enables

This unit sits beside a BCD calendar counter and raises an alarm when the live time matches a programmed alarm time. Software programs seven alarm fields: seconds, minutes, hours, weekday, day, month and year. Each field has its own enable bit, and only the enabled fields take part in the comparison. Leaving the coarser fields disabled gives a repeating alarm. For example, enabling only minutes and seconds fires once per hour.

The calendar core supplies the current field values and a one-cycle strobe each time the seconds count updates. The comparison is made only on that strobe. A match sets a sticky alarm flag in a status register, and an interrupt output stays high while that flag and the interrupt enable bit in a control register are both set. After any alarm register is written, the comparator stays blocked until a set number of periodic (1/64 s) ticks from the core have passed, so half-written alarm settings can never fire.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset, every register reads 0x00 and `alarm_irq` is low.
- R2: Alarm registers sit at byte addresses seconds 0x10, minutes 0x12, hours 0x14, weekday 0x16, day 0x18, month 0x1A and year 0x1C. For seconds through month, bit 7 is the field enable and the low bits hold the BCD value, with widths 7, 7, 6, 3, 6 and 5; the unused value bits read 0. The year value uses all 8 bits.
- R3: The year enable is bit 7 of a separate register at 0x1E, whose other bits read 0. Addresses that are not mapped read 0x00.
- R4: On a seconds strobe, a match occurs when every enabled field equals its counter. Disabled fields play no part, whatever their counter values.
- R5: When no field is enabled, no match occurs.
- R6: Matches are evaluated only in cycles where `sec_tick` is high. The flag (status register 0x20, bit 0) is set in the cycle after the strobe.
- R7: After any write to an alarm register or to the year enable register, no match is taken until `SETTLE_TICKS` (default 2) `per_tick` pulses have been seen, counting only pulses after the write.
- R8: The flag is sticky. Writing the status register with bit 0 = 0 clears it, and writing bit 0 = 1 has no effect.
- R9: If a match and a clearing write happen in the same cycle, the flag ends up set.
- R10: `alarm_irq` is high exactly when the flag and bit 0 of the control register (0x22) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write byte address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 6 | Register read byte address |
| rd_data | output | 8 | Register read data (combinational) |
| sec_tick | input | 1 | One-cycle strobe when the seconds count updates |
| per_tick | input | 1 | One-cycle 1/64 s periodic tick |
| cnt_sec | input | 7 | Live seconds, BCD |
| cnt_min | input | 7 | Live minutes, BCD |
| cnt_hour | input | 6 | Live hours, BCD |
| cnt_wday | input | 3 | Live weekday |
| cnt_day | input | 6 | Live day of month, BCD |
| cnt_mon | input | 5 | Live month, BCD |
| cnt_year | input | 8 | Live year, BCD |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The bench sweeps all 128 enable masks against nine patterns of mismatched fields. A comparator that compared disabled fields, ignored enabled ones, or fired with an empty mask would disagree with the expected result on some combination. Separate cases check the settle window. A unit that armed after one tick, or that let ticks from before a write count toward the window, would set the flag early. Other cases check a clearing write that lands on a matching strobe, where a design that gave the clear priority would lose the alarm. They also cover matches that are held without a strobe, which would fire repeatedly if the comparator were not gated by the strobe.

// File: rtl/cal_alarm_pkg.sv
// Package: shared constants for the calendar alarm unit.
// Assumes byte-addressed registers on even addresses in a 6-bit space.
package cal_alarm_pkg;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int NUM_FIELDS = 7;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_WDAY = 3;
    localparam int F_DAY  = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    localparam logic [ADDR_W-1:0] ALM_BASE = 6'h10;
    localparam logic [ADDR_W-1:0] YEN_ADDR = 6'h1E;
    localparam logic [ADDR_W-1:0] STS_ADDR = 6'h20;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 6'h22;

    typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] field_vec_t;

    // Width of the BCD value held by a field.
    function automatic int field_width(input int f);
        case (f)
            F_SEC, F_MIN: return 7;
            F_HOUR, F_DAY: return 6;
            F_WDAY: return 3;
            F_MON: return 5;
            default: return 8;
        endcase
    endfunction

    // Mask covering the value bits of a field.
    function automatic logic [DATA_W-1:0] field_mask(input int f);
        return DATA_W'((16'h1 << field_width(f)) - 16'h1);
    endfunction

    // Byte address of a field's alarm register.
    function automatic logic [ADDR_W-1:0] field_addr(input int f);
        return ALM_BASE + ADDR_W'(f * 2);
    endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
// Alarm value and enable storage.
// Holds the masked BCD value and the enable of each field. The year enable is
// written through its own address. Pulses alm_wr on any alarm-setting write.
module cal_alarm_regs
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output field_vec_t        alm_val,
    output logic [NUM_FIELDS-1:0] alm_en,
    output logic              alm_wr
);
    logic [NUM_FIELDS-1:0] hit_addr;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
        assign hit_addr[f] = wr_en && (wr_addr == field_addr(f));

        // Store the value bits of field f, dropping bits beyond its width.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alm_val[f] <= '0;
            end else if (hit_addr[f]) begin
                alm_val[f] <= wr_data & field_mask(f);
            end
        end

        if (f == F_YEAR) begin : g_yen
            // Year enable lives in its own register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    alm_en[f] <= 1'b0;
                end else if (wr_en && (wr_addr == YEN_ADDR)) begin
                    alm_en[f] <= wr_data[DATA_W-1];
                end
            end
        end else begin : g_en
            // Enable shares the byte with the value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    alm_en[f] <= 1'b0;
                end else if (hit_addr[f]) begin
                    alm_en[f] <= wr_data[DATA_W-1];
                end
            end
        end
    end

    assign alm_wr = (|hit_addr) || (wr_en && (wr_addr == YEN_ADDR));
endmodule

// File: rtl/cal_alarm_settle.sv
// Settle window after an alarm write.
// Counts periodic ticks after the latest alarm write and reports armed once
// SETTLE_TICKS ticks have been seen. A tick in the same cycle as a write is
// not counted.
module cal_alarm_settle #(
    parameter int SETTLE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alm_wr,
    input  logic per_tick,
    output logic armed
);
    localparam int CW = $clog2(SETTLE_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_TICKS);

    logic [CW-1:0] tick_cnt;

    // Restart on a write, otherwise count ticks up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= LIMIT;
        end else if (alm_wr) begin
            tick_cnt <= '0;
        end else if (per_tick && (tick_cnt != LIMIT)) begin
            tick_cnt <= tick_cnt + CW'(1);
        end
    end

    assign armed = (tick_cnt == LIMIT);
endmodule

// File: rtl/cal_alarm_match.sv
// Masked field comparator.
// A field passes when it is disabled or equal to its counter. A hit needs the
// seconds strobe, an armed unit, at least one enabled field and all fields
// passing.
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  field_vec_t            alm_val,
    input  logic [NUM_FIELDS-1:0] alm_en,
    input  field_vec_t            cnt_val,
    input  logic                  armed,
    input  logic                  sec_tick,
    output logic                  hit
);
    logic [NUM_FIELDS-1:0] fld_ok;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
        assign fld_ok[f] = !alm_en[f] || (alm_val[f] == cnt_val[f]);
    end

    assign hit = sec_tick && armed && (|alm_en) && (&fld_ok);
endmodule

// File: rtl/cal_alarm_flag.sv
// Status flag, interrupt enable and interrupt output.
// The flag is set by a hit and cleared by writing 0 to status bit 0; a hit wins
// over a clear in the same cycle.
module cal_alarm_flag
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit0,
    output logic              flag_q,
    output logic              ie_q,
    output logic              irq
);
    logic sts_wr;
    logic ctl_wr;

    assign sts_wr = wr_en && (wr_addr == STS_ADDR);
    assign ctl_wr = wr_en && (wr_addr == CTL_ADDR);

    // Sticky alarm flag: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (sts_wr && !wr_bit0) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (ctl_wr) begin
            ie_q <= wr_bit0;
        end
    end

    assign irq = flag_q && ie_q;
endmodule

// File: rtl/cal_alarm_unit.sv
// Top: alarm unit for a BCD calendar.
// Takes the live counters, a seconds strobe and a 1/64 s tick from the
// calendar core. Provides register write/read access and the alarm interrupt.
module cal_alarm_unit
    import cal_alarm_pkg::*;
#(
    parameter int SETTLE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sec_tick,
    input  logic              per_tick,
    input  logic [6:0]        cnt_sec,
    input  logic [6:0]        cnt_min,
    input  logic [5:0]        cnt_hour,
    input  logic [2:0]        cnt_wday,
    input  logic [5:0]        cnt_day,
    input  logic [4:0]        cnt_mon,
    input  logic [7:0]        cnt_year,
    output logic              alarm_irq
);
    field_vec_t            alm_val;
    field_vec_t            cnt_val;
    logic [NUM_FIELDS-1:0] alm_en;
    logic                  alm_wr;
    logic                  armed;
    logic                  hit;
    logic                  flag_q;
    logic                  ie_q;

    assign cnt_val[F_SEC]  = {1'b0, cnt_sec};
    assign cnt_val[F_MIN]  = {1'b0, cnt_min};
    assign cnt_val[F_HOUR] = {2'b0, cnt_hour};
    assign cnt_val[F_WDAY] = {5'b0, cnt_wday};
    assign cnt_val[F_DAY]  = {2'b0, cnt_day};
    assign cnt_val[F_MON]  = {3'b0, cnt_mon};
    assign cnt_val[F_YEAR] = cnt_year;

    cal_alarm_regs regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alm_val(alm_val), .alm_en(alm_en), .alm_wr(alm_wr)
    );

    cal_alarm_settle #(.SETTLE_TICKS(SETTLE_TICKS)) settle_i (
        .clk(clk), .rst_n(rst_n), .alm_wr(alm_wr), .per_tick(per_tick),
        .armed(armed)
    );

    cal_alarm_match match_i (
        .alm_val(alm_val), .alm_en(alm_en), .cnt_val(cnt_val),
        .armed(armed), .sec_tick(sec_tick), .hit(hit)
    );

    cal_alarm_flag flag_i (
        .clk(clk), .rst_n(rst_n), .hit(hit), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_bit0(wr_data[0]), .flag_q(flag_q),
        .ie_q(ie_q), .irq(alarm_irq)
    );

    // Read multiplexer over all mapped registers.
    always_comb begin
        rd_data = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (rd_addr == field_addr(f)) begin
                if (f == F_YEAR) begin
                    rd_data = alm_val[f];
                end else begin
                    rd_data = {alm_en[f], alm_val[f][DATA_W-2:0]};
                end
            end
        end
        if (rd_addr == YEN_ADDR) rd_data = {alm_en[F_YEAR], 7'b0};
        if (rd_addr == STS_ADDR) rd_data = {7'b0, flag_q};
        if (rd_addr == CTL_ADDR) rd_data = {7'b0, ie_q};
    end
endmodule

// File: rtl/cal_alarm_unit_chk.sv
// Checker for cal_alarm_unit, bound to the top. Relates the flag to its causes.
module cal_alarm_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       wr_en,
    input logic [5:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       alarm_irq,
    input logic       flag_q,
    input logic       ie_q,
    input logic       armed,
    input logic [6:0] alm_en
);
    // R1: the interrupt is low in the cycle after a reset cycle.
    a_r1_irq_low_after_reset: assert property (@(posedge clk)
        !rst_n |=> !alarm_irq);

    // R6: the flag only rises after a seconds strobe.
    a_r6_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(sec_tick));

    // R7: the flag never rises while the settle window is open.
    a_r7_rise_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(armed));

    // R5: the flag never rises with an empty enable set.
    a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(alm_en) != 7'b0));

    // R8: the flag only falls after a clearing status write.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(wr_en && (wr_addr == 6'h20) && !wr_data[0]));

    // R10: the interrupt never stands without its enable.
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> ie_q);
endmodule

bind cal_alarm_unit cal_alarm_unit_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .alarm_irq(alarm_irq),
    .flag_q(flag_q), .ie_q(ie_q), .armed(armed), .alm_en(alm_en)
);

// File: tb/cal_alarm_unit_tb_top.sv
`timescale 1ns/1ps
module cal_alarm_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sec_tick = 1'b0;
    logic       per_tick = 1'b0;
    logic [7:0] cur [7];
    logic       alarm_irq;

    int total = 0;
    int bad   = 0;

    localparam logic [7:0] BASE [7] = '{8'h45, 8'h30, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99};

    always #2 clk = ~clk;

    cal_alarm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sec_tick(sec_tick), .per_tick(per_tick),
        .cnt_sec(cur[0][6:0]), .cnt_min(cur[1][6:0]), .cnt_hour(cur[2][5:0]),
        .cnt_wday(cur[3][2:0]), .cnt_day(cur[4][5:0]), .cnt_mon(cur[5][4:0]),
        .cnt_year(cur[6]), .alarm_irq(alarm_irq)
    );

    function automatic logic [5:0] addr_of(input int f);
        return 6'h10 + 6'(2 * f);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ptick();
        @(negedge clk); per_tick = 1'b1;
        @(negedge clk); per_tick = 1'b0;
    endtask

    task automatic stick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    // Program all fields with BASE values and the given enable mask.
    task automatic program_alarm(input logic [6:0] m);
        for (int f = 0; f < 6; f++) wr(addr_of(f), {m[f], BASE[f][6:0]});
        wr(6'h1C, BASE[6]);
        wr(6'h1E, {m[6], 7'b0});
    endtask

    task automatic set_counters(input logic [6:0] d);
        for (int f = 0; f < 7; f++) cur[f] = d[f] ? (BASE[f] ^ 8'h01) : BASE[f];
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [6:0] dpat [9];
        for (int f = 0; f < 7; f++) cur[f] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of all registers and the interrupt.
        for (int a = 0; a < 64; a += 2) begin
            rd(6'(a), v);
            check("R1 reset read", v, 8'h00);
        end
        check("R1 reset irq", {7'b0, alarm_irq}, 8'h00);

        // R2: value masks and enable bit per field.
        for (int f = 0; f < 6; f++) begin
            wr(addr_of(f), 8'hFF);
            rd(addr_of(f), v);
            check("R2 field mask", v, 8'h80 | 8'((16'h1 << (f == 3 ? 3 : f == 5 ? 5 : (f == 2 || f == 4) ? 6 : 7)) - 1));
        end
        wr(6'h1C, 8'hFF); rd(6'h1C, v);
        check("R2 year full width", v, 8'hFF);
        // R3: separate year enable register and unmapped addresses.
        wr(6'h1E, 8'hFF); rd(6'h1E, v);
        check("R3 year enable", v, 8'h80);
        wr(6'h24, 8'hFF); rd(6'h24, v);
        check("R3 unmapped", v, 8'h00);

        wr(6'h22, 8'h01);
        dpat[0] = 7'h00; dpat[8] = 7'h7F;
        for (int k = 0; k < 7; k++) dpat[k+1] = 7'(1 << k);

        // R4 R5: sweep every enable mask against mismatch patterns.
        for (int m = 0; m < 128; m++) begin
            for (int p = 0; p < 9; p++) begin
                logic e;
                program_alarm(7'(m));
                wr(6'h20, 8'h00);
                ptick(); ptick();
                set_counters(dpat[p]);
                stick();
                e = (m != 0) && ((7'(m) & dpat[p]) == 7'h00);
                rd(6'h20, v);
                check(m == 0 ? "R5 empty mask flag" : "R4 masked match flag", v, {7'b0, e});
                check("R10 irq follows flag", {7'b0, alarm_irq}, {7'b0, e});
            end
        end

        // R7: one tick is not enough; a write restarts the window.
        program_alarm(7'h7F); set_counters(7'h00); wr(6'h20, 8'h00);
        ptick(); stick(); rd(6'h20, v);
        check("R7 one tick not armed", v, 8'h00);
        ptick(); wr(6'h10, {1'b1, BASE[0][6:0]}); ptick(); stick(); rd(6'h20, v);
        check("R7 write restarts window", v, 8'h00);
        ptick(); stick(); rd(6'h20, v);
        check("R7 armed after ticks", v, 8'h01);

        // R6: no strobe, no match.
        wr(6'h20, 8'h00);
        repeat (6) @(negedge clk);
        rd(6'h20, v);
        check("R6 no strobe no flag", v, 8'h00);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; rd(6'h20, v);
        check("R6 flag next cycle", v, 8'h01);

        // R8: write 1 no effect, write 0 clears.
        wr(6'h20, 8'h01); rd(6'h20, v);
        check("R8 write one keeps flag", v, 8'h01);
        wr(6'h20, 8'hFE); rd(6'h20, v);
        check("R8 write zero clears", v, 8'h00);
        wr(6'h20, 8'h01); rd(6'h20, v);
        check("R8 write one does not set", v, 8'h00);

        // R9: set wins over a same-cycle clear.
        @(negedge clk); sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 6'h20; wr_data = 8'h00;
        @(negedge clk); sec_tick = 1'b0; wr_en = 1'b0; rd(6'h20, v);
        check("R9 set beats clear", v, 8'h01);

        // R10: interrupt enable gating.
        wr(6'h22, 8'h00);
        check("R10 irq masked", {7'b0, alarm_irq}, 8'h00);
        wr(6'h22, 8'h01);
        check("R10 irq enabled", {7'b0, alarm_irq}, 8'h01);
        wr(6'h20, 8'h00);
        check("R10 irq drops with flag", {7'b0, alarm_irq}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule